// File: doc/BRIEF.md
# Word ALU with Overflow Side Register

This block performs the arithmetic, logic, shift and test operations of a 16-bit processor datapath. A request carries a 5-bit operation code, a destination operand `b`, a source operand `a` and the present contents of the overflow side register. The block returns the new value for `b`, a new side-register value with a write strobe, and a test flag for the conditional-skip operations. Operand fetch, the register file and the skipping of later instructions are left to the surrounding core.

Requests are accepted with a one-cycle `start` while the block is idle. Single-step operations complete in the next cycle. Multiplies run on an iterative shift-add engine. Divides and remainders run on an iterative restoring divider. That divider produces the integer quotient, the 16-bit fractional quotient used as the side result, and the remainder in a single pass. The controller is a four-state machine: `ST_IDLE` waits for `start`. It moves to `ST_MUL` for multiplies, to `ST_DIV` for divides and remainders, and to `ST_DONE` for everything else. `ST_MUL` and `ST_DIV` move to `ST_DONE` when their engine reports completion. `ST_DONE` presents `done` for one cycle and returns to `ST_IDLE`. All results are registered and stay on the outputs until the next completion.

Top module: `ovf_alu`

## Requirements
- R1: After reset, `done`, `ex_we` and `cond_true` are low, and `result` and `ex_out` are zero.
- R2: `start` is taken only in `ST_IDLE` and is ignored otherwise. `done` is a one-cycle pulse that appears in the cycle after `start` for single-step opcodes. For multiplies it appears W+2 (18) cycles after `start`, and for divides and remainders 2W+2 (34) cycles after `start`.
- R3: ADD (5'h02) returns b+a and sets EX to 1 on a carry out of bit 15, else 0. SUB (5'h03) returns b-a and sets EX to 16'hFFFF on a borrow, else 0.
- R4: ADDC (5'h1A) returns b+a+EX and sets EX to 1 if the true sum exceeds 16'hFFFF, else 0. SUBC (5'h1B) returns b-a+EX and sets EX to 16'hFFFF if the true value is negative, else 0.
- R5: MULU (5'h04) and MULS (5'h05) return the low half of the 32-bit product and set EX to the high half. MULU treats both operands as unsigned, and MULS treats both as two's complement.
- R6: DIVU (5'h06) returns b/a and sets EX to the low 16 bits of (b<<16)/a, both unsigned. DIVS (5'h07) does the same on signed values with truncation toward zero, and 16'h8000 divided by 16'hFFFF returns 16'h8000.
- R7: REMU (5'h08) returns b mod a unsigned. REMS (5'h09) returns the signed remainder carrying the sign of b, so that -7 and 16 give -7. Neither writes EX.
- R8: When a is zero, DIVU and DIVS return 0 with EX 0, and REMU and REMS return 0.
- R9: SRL (5'h0D) returns b>>a with EX = low 16 bits of ((b<<16)>>a). SRA (5'h0E) shifts b as signed with EX = low 16 bits of the sign-extended ((b<<16)>>>a). SLL (5'h0F) returns b<<a with EX = bits 31:16 of (b<<a).
- R10: The full 16-bit value of a is the shift count. A count of 16 or more makes the SRL and SLL result zero and the SRA result all copies of b[15], while EX still follows the full 32-bit shift.
- R11: For 5'h10 to 5'h17, `cond_true` is high with `done` when, in opcode order, (b&a)!=0, (b&a)==0, b==a, b!=a, b>a unsigned, b>a signed, b<a unsigned, or b<a signed holds. `cond_true` stays low for every other opcode.
- R12: AND (5'h0A), OR (5'h0B) and XOR (5'h0C) return the bitwise result. MOVE (5'h01), MOVEI (5'h1E) and MOVED (5'h1F) return a. Test opcodes and unassigned opcodes (5'h00, 5'h18, 5'h19, 5'h1C, 5'h1D) return b.
- R13: `ex_we` is high with `done` exactly for ADD, SUB, MULU, MULS, DIVU, DIVS, ADDC, SUBC, SRL, SRA and SLL. When it is low, `ex_out` equals the EX value taken with `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| opcode | input | 5 | Operation code |
| opnd_b | input | W (16) | Destination operand b |
| opnd_a | input | W (16) | Source operand a |
| ex_in | input | W (16) | Current overflow side register |
| result | output | W (16) | New value for b |
| ex_out | output | W (16) | New overflow side register value |
| ex_we | output | 1 | Side register write strobe, valid with done |
| cond_true | output | 1 | Test outcome, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong controller state shows up as a `done` pulse at the wrong cycle distance from `start`, a missing pulse, or a second pulse. The bench measures the latency of every request, and the bound checker counts the cycles independently. A corrupted engine register, such as a lost count, a wrong partial remainder or a dropped quotient bit, shows up only in `result` or `ex_out` at the single `done` cycle of that request. For that reason the divide cases use operands whose fractional quotient and remainder both depend on every iteration. A request issued while busy would show up as a changed result or an extra `done` within three cycles of the first one.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

    typedef enum logic [4:0] {
        OP_NONE  = 5'h00,
        OP_MOVE  = 5'h01,
        OP_ADD   = 5'h02,
        OP_SUB   = 5'h03,
        OP_MULU  = 5'h04,
        OP_MULS  = 5'h05,
        OP_DIVU  = 5'h06,
        OP_DIVS  = 5'h07,
        OP_REMU  = 5'h08,
        OP_REMS  = 5'h09,
        OP_AND   = 5'h0A,
        OP_OR    = 5'h0B,
        OP_XOR   = 5'h0C,
        OP_SRL   = 5'h0D,
        OP_SRA   = 5'h0E,
        OP_SLL   = 5'h0F,
        OP_TSTNZ = 5'h10,
        OP_TSTZ  = 5'h11,
        OP_EQ    = 5'h12,
        OP_NE    = 5'h13,
        OP_GTU   = 5'h14,
        OP_GTS   = 5'h15,
        OP_LTU   = 5'h16,
        OP_LTS   = 5'h17,
        OP_ADDC  = 5'h1A,
        OP_SUBC  = 5'h1B,
        OP_MOVEI = 5'h1E,
        OP_MOVED = 5'h1F
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_DONE
    } st_e;

    function automatic logic op_is_mul(op_e o);
        return (o == OP_MULU) || (o == OP_MULS);
    endfunction

    function automatic logic op_is_div(op_e o);
        return (o == OP_DIVU) || (o == OP_DIVS) || (o == OP_REMU) || (o == OP_REMS);
    endfunction

    function automatic logic op_is_rem(op_e o);
        return (o == OP_REMU) || (o == OP_REMS);
    endfunction

    function automatic logic op_is_signed(op_e o);
        return (o == OP_MULS) || (o == OP_DIVS) || (o == OP_REMS);
    endfunction

    function automatic logic op_is_cmp(op_e o);
        logic [4:0] v;
        v = o;
        return v[4:3] == 2'b10;
    endfunction

    function automatic logic op_writes_ex(op_e o);
        case (o)
            OP_ADD, OP_SUB, OP_MULU, OP_MULS, OP_DIVU, OP_DIVS,
            OP_ADDC, OP_SUBC, OP_SRL, OP_SRA, OP_SLL: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ovf_alu_single.sv
// Single-step operations: add/sub with flags, logic, shifts, tests, moves.
module ovf_alu_single import ovf_alu_pkg::*; #(
    parameter int unsigned W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] b,
    input  logic [W-1:0] a,
    input  logic [W-1:0] exi,
    output logic [W-1:0] res,
    output logic [W-1:0] exn,
    output logic         we,
    output logic         cond
);
    localparam logic [W-1:0] EX_ONE  = W'(1);
    localparam logic [W-1:0] EX_ALL1 = '1;

    logic [W:0]     sum1;
    logic [W:0]     dif1;
    logic [W+1:0]   sumc;
    logic [W+1:0]   difc;
    logic [2*W-1:0] shr_v;
    logic [2*W-1:0] sra_v;
    logic [2*W-1:0] shl_v;
    logic [W-1:0]   andv;

    always_comb begin
        sum1  = {1'b0, b} + {1'b0, a};
        dif1  = {1'b0, b} - {1'b0, a};
        sumc  = {2'b00, b} + {2'b00, a} + {2'b00, exi};
        difc  = {2'b00, b} - {2'b00, a} + {2'b00, exi};
        shr_v = {b, {W{1'b0}}} >> a;
        sra_v = $signed({b, {W{1'b0}}}) >>> a;
        shl_v = {{W{1'b0}}, b} << a;
        andv  = b & a;
    end

    always_comb begin
        res  = b;
        exn  = exi;
        we   = 1'b0;
        cond = 1'b0;
        case (op)
            OP_MOVE, OP_MOVEI, OP_MOVED: res = a;
            OP_ADD: begin
                res = sum1[W-1:0];
                exn = sum1[W] ? EX_ONE : '0;
                we  = 1'b1;
            end
            OP_SUB: begin
                res = dif1[W-1:0];
                exn = dif1[W] ? EX_ALL1 : '0;
                we  = 1'b1;
            end
            OP_ADDC: begin
                res = sumc[W-1:0];
                exn = (sumc[W+1:W] != 2'b00) ? EX_ONE : '0;
                we  = 1'b1;
            end
            OP_SUBC: begin
                res = difc[W-1:0];
                exn = difc[W+1] ? EX_ALL1 : '0;
                we  = 1'b1;
            end
            OP_AND: res = andv;
            OP_OR:  res = b | a;
            OP_XOR: res = b ^ a;
            OP_SRL: begin
                res = shr_v[2*W-1:W];
                exn = shr_v[W-1:0];
                we  = 1'b1;
            end
            OP_SRA: begin
                res = sra_v[2*W-1:W];
                exn = sra_v[W-1:0];
                we  = 1'b1;
            end
            OP_SLL: begin
                res = shl_v[W-1:0];
                exn = shl_v[2*W-1:W];
                we  = 1'b1;
            end
            OP_TSTNZ: cond = (andv != '0);
            OP_TSTZ:  cond = (andv == '0);
            OP_EQ:    cond = (b == a);
            OP_NE:    cond = (b != a);
            OP_GTU:   cond = (b > a);
            OP_GTS:   cond = ($signed(b) > $signed(a));
            OP_LTU:   cond = (b < a);
            OP_LTS:   cond = ($signed(b) < $signed(a));
            default: ;
        endcase
    end
endmodule

// File: rtl/ovf_alu_mul.sv
// Iterative unsigned shift-add multiplier, one partial product per cycle.
module ovf_alu_mul #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod,
    output logic           fin
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [2*W-1:0] acc_q;
    logic [2*W-1:0] mc_q;
    logic [W-1:0]   mp_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic           fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mc_q   <= '0;
            mp_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else if (go) begin
            acc_q  <= '0;
            mc_q   <= {{W{1'b0}}, mcand};
            mp_q   <= mplier;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign prod = acc_q;
    assign fin  = fin_q;
endmodule

// File: rtl/ovf_alu_div.sv
// Iterative restoring divider on {dvd_hi, W zeros} / dsr over 2W steps.
// Quotient high half = integer quotient, low half = fractional quotient;
// the partial remainder after W steps is dvd_hi mod dsr.
module ovf_alu_div #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dsr,
    output logic [2*W-1:0] quot,
    output logic [W-1:0]   rem_mid,
    output logic           fin
);
    localparam int unsigned CW = $clog2(2 * W);
    localparam logic [CW-1:0] LAST = CW'(2 * W - 1);
    localparam logic [CW-1:0] MID  = CW'(W - 1);

    logic [2*W-1:0] dvd_q;
    logic [W-1:0]   rem_q;
    logic [W-1:0]   dsr_q;
    logic [W-1:0]   mid_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic           fin_q;

    logic [W:0]     trial;
    logic           ge;
    logic [W:0]     rem_n;

    always_comb begin
        trial = {rem_q, dvd_q[2*W-1]};
        ge    = (trial >= {1'b0, dsr_q});
        rem_n = ge ? (trial - {1'b0, dsr_q}) : trial;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            mid_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else if (go) begin
            dvd_q  <= {dvd_hi, {W{1'b0}}};
            rem_q  <= '0;
            dsr_q  <= dsr;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            dvd_q <= {dvd_q[2*W-2:0], ge};
            rem_q <= rem_n[W-1:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID) begin
                mid_q <= rem_n[W-1:0];
            end
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign quot    = dvd_q;
    assign rem_mid = mid_q;
    assign fin     = fin_q;
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu import ovf_alu_pkg::*; #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [4:0]   opcode,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] ex_in,
    output logic [W-1:0] result,
    output logic [W-1:0] ex_out,
    output logic         ex_we,
    output logic         cond_true,
    output logic         done
);
    st_e            state_q, state_d;
    op_e            op_in;
    op_e            op_q;
    logic [W-1:0]   b_q, a_q, exi_q;
    logic           accept;

    logic [W-1:0]   s_res, s_ex;
    logic           s_we, s_cond;

    logic           mul_go, mul_fin;
    logic [2*W-1:0] mul_prod;
    logic           div_go, div_fin, div_sgn;
    logic [W-1:0]   mag_b, mag_a;
    logic [2*W-1:0] div_quot;
    logic [W-1:0]   div_rem;

    logic [2*W-1:0] mul_fix;
    logic [W-1:0]   div_res, div_ex;
    logic           div_we;
    logic           neg_q, neg_r, dz;

    logic [W-1:0]   res_q, exo_q;
    logic           we_q, cond_q;

    assign op_in   = op_e'(opcode);
    assign accept  = start && (state_q == ST_IDLE);
    assign mul_go  = accept && op_is_mul(op_in);
    assign div_go  = accept && op_is_div(op_in);
    assign div_sgn = op_is_signed(op_in);
    assign mag_b   = (div_sgn && opnd_b[W-1]) ? (-opnd_b) : opnd_b;
    assign mag_a   = (div_sgn && opnd_a[W-1]) ? (-opnd_a) : opnd_a;

    ovf_alu_single #(.W(W)) u_single (
        .op   (op_in),
        .b    (opnd_b),
        .a    (opnd_a),
        .exi  (ex_in),
        .res  (s_res),
        .exn  (s_ex),
        .we   (s_we),
        .cond (s_cond)
    );

    ovf_alu_mul #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (mul_go),
        .mcand  (opnd_b),
        .mplier (opnd_a),
        .prod   (mul_prod),
        .fin    (mul_fin)
    );

    ovf_alu_div #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .dvd_hi  (mag_b),
        .dsr     (mag_a),
        .quot    (div_quot),
        .rem_mid (div_rem),
        .fin     (div_fin)
    );

    // Operand capture for post-processing of iterative results.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            b_q   <= '0;
            a_q   <= '0;
            exi_q <= '0;
        end else if (accept) begin
            op_q  <= op_in;
            b_q   <= opnd_b;
            a_q   <= opnd_a;
            exi_q <= ex_in;
        end
    end

    // Signed product correction and divider sign/zero handling.
    always_comb begin
        mul_fix = mul_prod;
        if (op_q == OP_MULS) begin
            mul_fix = mul_prod
                    - (b_q[W-1] ? {a_q, {W{1'b0}}} : '0)
                    - (a_q[W-1] ? {b_q, {W{1'b0}}} : '0);
        end
        dz     = (a_q == '0);
        neg_q  = op_is_signed(op_q) && (b_q[W-1] ^ a_q[W-1]);
        neg_r  = op_is_signed(op_q) && b_q[W-1];
        div_we = !op_is_rem(op_q);
        if (op_is_rem(op_q)) begin
            div_res = dz ? '0 : (neg_r ? (-div_rem) : div_rem);
            div_ex  = exi_q;
        end else begin
            div_res = dz ? '0 : (neg_q ? (-div_quot[2*W-1:W]) : div_quot[2*W-1:W]);
            div_ex  = dz ? '0 : (neg_q ? (-div_quot[W-1:0]) : div_quot[W-1:0]);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (op_is_mul(op_in)) begin
                        state_d = ST_MUL;
                    end else if (op_is_div(op_in)) begin
                        state_d = ST_DIV;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_MUL:  if (mul_fin) state_d = ST_DONE;
            ST_DIV:  if (div_fin) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            exo_q  <= '0;
            we_q   <= 1'b0;
            cond_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && !op_is_mul(op_in) && !op_is_div(op_in)) begin
                        res_q  <= s_res;
                        exo_q  <= s_ex;
                        we_q   <= s_we;
                        cond_q <= s_cond;
                    end
                end
                ST_MUL: begin
                    if (mul_fin) begin
                        res_q  <= mul_fix[W-1:0];
                        exo_q  <= mul_fix[2*W-1:W];
                        we_q   <= 1'b1;
                        cond_q <= 1'b0;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        res_q  <= div_res;
                        exo_q  <= div_ex;
                        we_q   <= div_we;
                        cond_q <= 1'b0;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    assign done      = (state_q == ST_DONE);
    assign result    = res_q;
    assign ex_out    = exo_q;
    assign ex_we     = done && we_q;
    assign cond_true = done && cond_q;
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk import ovf_alu_pkg::*; #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [4:0]   opcode,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] ex_in,
    input logic [W-1:0] result,
    input logic [W-1:0] ex_out,
    input logic         ex_we,
    input logic         cond_true,
    input logic         done
);
    localparam int unsigned LAT_ONE = 1;
    localparam int unsigned LAT_MUL = W + 2;
    localparam int unsigned LAT_DIV = 2 * W + 2;
    localparam int unsigned NW      = $clog2(LAT_DIV + 2) + 1;

    logic          pend_q;
    logic [NW-1:0] cnt_q;
    op_e           op_seen;
    logic [W-1:0]  a_seen, ex_seen;
    logic [NW-1:0] exp_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            op_seen <= OP_NONE;
            a_seen  <= '0;
            ex_seen <= '0;
        end else if (start && !pend_q) begin
            pend_q  <= 1'b1;
            cnt_q   <= NW'(1);
            op_seen <= op_e'(opcode);
            a_seen  <= opnd_a;
            ex_seen <= ex_in;
        end else if (pend_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (op_is_mul(op_seen))      exp_lat = NW'(LAT_MUL);
        else if (op_is_div(op_seen)) exp_lat = NW'(LAT_DIV);
        else                         exp_lat = NW'(LAT_ONE);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rst_n) done |-> pend_q); // R2
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cnt_q == exp_lat)); // R2
    AST_ADD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (done && op_seen == OP_ADD) |-> (ex_out <= W'(1))); // R3
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && op_is_div(op_seen) && a_seen == '0) |-> (result == '0)); // R8
    AST_COND_SCOPE: assert property (@(posedge clk) disable iff (!rst_n) (done && !op_is_cmp(op_seen)) |-> !cond_true); // R11
    AST_EXWE_SET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ex_we == op_writes_ex(op_seen))); // R13
    AST_EX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !ex_we) |-> (ex_out == ex_seen)); // R13
endmodule

bind ovf_alu ovf_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .opnd_a    (opnd_a),
    .ex_in     (ex_in),
    .result    (result),
    .ex_out    (ex_out),
    .ex_we     (ex_we),
    .cond_true (cond_true),
    .done      (done)
);

// File: tb/ovf_alu_tb_top.sv
module ovf_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  opcode = '0;
    logic [15:0] opnd_b = '0, opnd_a = '0, ex_in = '0;
    logic [15:0] result, ex_out;
    logic        ex_we, cond_true, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    ovf_alu #(.W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opnd_b(opnd_b), .opnd_a(opnd_a), .ex_in(ex_in),
        .result(result), .ex_out(ex_out), .ex_we(ex_we),
        .cond_true(cond_true), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WDOG_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Reference from the requirements.
    task automatic predict(input logic [4:0] op, input logic [15:0] b, a, ex,
                           output logic [15:0] r, output logic [15:0] e,
                           output logic w, output logic c, output int lat);
        longint ub, ua, ue, sb, sa, t;
        ub = longint'(b); ua = longint'(a); ue = longint'(ex);
        sb = longint'($signed(b)); sa = longint'($signed(a));
        r = b; e = ex; w = 1'b0; c = 1'b0; lat = 1;
        case (op)
            5'h01, 5'h1E, 5'h1F: r = a;
            5'h02: begin t = ub + ua; r = t[15:0]; e = (t > 65535) ? 16'h1 : 16'h0; w = 1; end
            5'h03: begin t = ub - ua; r = t[15:0]; e = (t < 0) ? 16'hFFFF : 16'h0; w = 1; end
            5'h04: begin t = ub * ua; r = t[15:0]; e = t[31:16]; w = 1; lat = 18; end
            5'h05: begin t = sb * sa; r = t[15:0]; e = t[31:16]; w = 1; lat = 18; end
            5'h06: begin
                w = 1; lat = 34;
                if (a == 0) begin r = 0; e = 0; end
                else begin t = ub / ua; r = t[15:0]; t = (ub * 65536) / ua; e = t[15:0]; end
            end
            5'h07: begin
                w = 1; lat = 34;
                if (a == 0) begin r = 0; e = 0; end
                else begin t = sb / sa; r = t[15:0]; t = (sb * 65536) / sa; e = t[15:0]; end
            end
            5'h08: begin lat = 34; if (a == 0) r = 0; else begin t = ub % ua; r = t[15:0]; end end
            5'h09: begin lat = 34; if (a == 0) r = 0; else begin t = sb % sa; r = t[15:0]; end end
            5'h0A: r = b & a;
            5'h0B: r = b | a;
            5'h0C: r = b ^ a;
            5'h0D: begin t = (ub << 16) >> ua; r = t[31:16]; e = t[15:0]; w = 1; end
            5'h0E: begin t = (sb <<< 16) >>> ua; r = t[31:16]; e = t[15:0]; w = 1; end
            5'h0F: begin t = ub << ua; r = t[15:0]; e = t[31:16]; w = 1; end
            5'h10: c = ((b & a) != 0);
            5'h11: c = ((b & a) == 0);
            5'h12: c = (b == a);
            5'h13: c = (b != a);
            5'h14: c = (ub > ua);
            5'h15: c = (sb > sa);
            5'h16: c = (ub < ua);
            5'h17: c = (sb < sa);
            5'h1A: begin t = ub + ua + ue; r = t[15:0]; e = (t > 65535) ? 16'h1 : 16'h0; w = 1; end
            5'h1B: begin t = ub - ua + ue; r = t[15:0]; e = (t < 0) ? 16'hFFFF : 16'h0; w = 1; end
            default: ;
        endcase
    endtask

    // Issue one request and measure cycles until done.
    task automatic issue(input logic [4:0] op, input logic [15:0] b, a, ex, output int lat);
        @(negedge clk);
        start = 1'b1; opcode = op; opnd_b = b; opnd_a = a; ex_in = ex;
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) break;
        end
        if (!done) lat = -1;
    endtask

    task automatic run_op(string tag, input logic [4:0] op, input logic [15:0] b, a, ex);
        logic [15:0] er, ee; logic ew, ec; int el, al;
        predict(op, b, a, ex, er, ee, ew, ec, el);
        issue(op, b, a, ex, al);
        chk("R2", $sformatf("latency op=%h", op), 16'(al), 16'(el));
        chk(tag, $sformatf("result op=%h b=%h a=%h", op, b, a), result, er);
        chk(tag, $sformatf("ex op=%h b=%h a=%h", op, b, a), ex_out, ee);
        chk("R13", $sformatf("ex_we op=%h", op), 16'(ex_we), 16'(ew));
        chk("R11", $sformatf("cond op=%h b=%h a=%h", op, b, a), 16'(cond_true), 16'(ec));
    endtask

    task automatic t_reset();
        chk("R1", "done", 16'(done), 16'h0);
        chk("R1", "ex_we", 16'(ex_we), 16'h0);
        chk("R1", "cond_true", 16'(cond_true), 16'h0);
        chk("R1", "result", result, 16'h0);
        chk("R1", "ex_out", ex_out, 16'h0);
    endtask

    task automatic t_addsub(); // R3
        run_op("R3", 5'h02, 16'h1234, 16'h0F0F, 16'h5555);
        run_op("R3", 5'h02, 16'hFFFF, 16'h0002, 16'h0000);
        run_op("R3", 5'h03, 16'h0005, 16'h0003, 16'h0001);
        run_op("R3", 16'h03, 16'h0003, 16'h0005, 16'h0000);
    endtask

    task automatic t_carry(); // R4
        run_op("R4", 5'h1A, 16'hFFFF, 16'h0000, 16'h0001);
        run_op("R4", 5'h1A, 16'h1000, 16'h2000, 16'h0001);
        run_op("R4", 5'h1B, 16'h0005, 16'h0007, 16'h0001);
        run_op("R4", 5'h1B, 16'h0005, 16'h0003, 16'h0000);
    endtask

    task automatic t_mul(); // R5
        run_op("R5", 5'h04, 16'hFFFF, 16'hFFFF, 16'h0000);
        run_op("R5", 5'h04, 16'h0123, 16'h0456, 16'h0000);
        run_op("R5", 5'h05, 16'hFFFE, 16'h0003, 16'h0000);
        run_op("R5", 5'h05, 16'h8000, 16'h8000, 16'h0000);
    endtask

    task automatic t_div(); // R6
        run_op("R6", 5'h06, 16'h0007, 16'h0003, 16'h0000);
        run_op("R6", 5'h06, 16'hFFFF, 16'h0013, 16'h0000);
        run_op("R6", 5'h07, 16'hFFF9, 16'h0002, 16'h0000);
        run_op("R6", 5'h07, 16'h8000, 16'hFFFF, 16'h0000);
        run_op("R6", 5'h07, 16'hFFFF, 16'h0002, 16'h0000);
    endtask

    task automatic t_rem(); // R7
        run_op("R7", 5'h08, 16'h0064, 16'h0007, 16'hABCD);
        run_op("R7", 5'h09, 16'hFFF9, 16'h0010, 16'h1357);
        run_op("R7", 5'h09, 16'h0007, 16'hFFFD, 16'h0000);
    endtask

    task automatic t_divzero(); // R8
        run_op("R8", 5'h06, 16'h1234, 16'h0000, 16'h7777);
        run_op("R8", 5'h07, 16'h8001, 16'h0000, 16'h7777);
        run_op("R8", 5'h08, 16'h1234, 16'h0000, 16'h4444);
        run_op("R8", 5'h09, 16'hF234, 16'h0000, 16'h4444);
    endtask

    task automatic t_shift(); // R9
        run_op("R9", 5'h0D, 16'hB6C5, 16'h0004, 16'h0000);
        run_op("R9", 5'h0E, 16'hB6C5, 16'h0004, 16'h0000);
        run_op("R9", 5'h0F, 16'hB6C5, 16'h0005, 16'h0000);
        run_op("R9", 5'h0D, 16'h8001, 16'h0000, 16'h1111);
    endtask

    task automatic t_bigshift(); // R10
        run_op("R10", 5'h0D, 16'hB6C5, 16'h0014, 16'h0000);
        run_op("R10", 5'h0E, 16'hB6C5, 16'h0012, 16'h0000);
        run_op("R10", 5'h0F, 16'hB6C5, 16'h0014, 16'h0000);
        run_op("R10", 5'h0E, 16'h8000, 16'h0040, 16'h0000);
        run_op("R10", 5'h0F, 16'h00FF, 16'h0010, 16'h0000);
    endtask

    task automatic t_compare(); // R11
        for (int k = 0; k < 8; k++) begin
            run_op("R11", 5'(16 + k), 16'hFFF0, 16'h0010, 16'h2222);
            run_op("R11", 5'(16 + k), 16'h0003, 16'h0003, 16'h2222);
            run_op("R11", 5'(16 + k), 16'h0010, 16'hFFF0, 16'h2222);
        end
    endtask

    task automatic t_logic_move(); // R12
        run_op("R12", 5'h0A, 16'hF0F0, 16'h3C3C, 16'h9999);
        run_op("R12", 5'h0B, 16'hF0F0, 16'h3C3C, 16'h9999);
        run_op("R12", 5'h0C, 16'hF0F0, 16'h3C3C, 16'h9999);
        run_op("R12", 5'h01, 16'h1111, 16'hBEEF, 16'h9999);
        run_op("R12", 5'h1E, 16'h1111, 16'hCAFE, 16'h9999);
        run_op("R12", 5'h1F, 16'h1111, 16'hD00D, 16'h9999);
        run_op("R12", 5'h00, 16'h4321, 16'h5678, 16'h9999);
        run_op("R12", 5'h18, 16'h4321, 16'h5678, 16'h9999);
        run_op("R12", 5'h1D, 16'h4321, 16'h5678, 16'h9999);
    endtask

    task automatic t_busy_start(); // R2: start while busy is ignored
        logic [15:0] er, ee; logic ew, ec; int el, lat;
        predict(5'h04, 16'h012C, 16'h01F4, 16'h0000, er, ee, ew, ec, el);
        @(negedge clk);
        start = 1'b1; opcode = 5'h04; opnd_b = 16'h012C; opnd_a = 16'h01F4; ex_in = 16'h0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        start = 1'b1; opcode = 5'h02; opnd_b = 16'h0001; opnd_a = 16'h0001; ex_in = 16'h3333;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk("R2", "busy latency", 16'(lat), 16'(el));
        chk("R2", "busy result", result, er);
        chk("R2", "busy ex", ex_out, ee);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2", "no extra done", 16'(done), 16'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addsub();
        t_carry();
        t_mul();
        t_div();
        t_rem();
        t_divzero();
        t_shift();
        t_bigshift();
        t_compare();
        t_logic_move();
        t_busy_start();
        run_op("R6", 5'h06, 16'hABCD, 16'h0123, 16'h0000);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule